// File: doc/BRIEF.md
# Draw-Side Command Packet Parser

This block sits at the front of a draw engine. It reads a stream of 32-bit command words, one per accepted cycle, and splits it into packets. The header of each packet carries a type, an opcode and a length. Register-set packets become a burst of register-file writes at consecutive word addresses. Each of the three register classes adds its own base address to the offset carried in the packet.

Two opcodes keep the draw engine in step with a companion constant engine. One adds one to a local draw counter. The other holds the input stream until the companion's counter, an input, is ahead of the draw counter. Draw, dispatch, event and memory opcodes are not executed here. They leave as a one-cycle opcode strobe followed by their body words. A no-op packet can carry a marker that raises a flip pulse. Malformed or unknown packets set a sticky error flag and are dropped.

Top module: `cmd_parser`

## Requirements
- R1: A header has type in bits 31:30, a count field in bits 29:16 and the opcode in bits 15:8. Only type 3 is a valid header. A type-3 packet has count+1 body words, and the word after its last body word is taken as the next header.
- R2: Opcode 0x69 is a context register set. Its first body word gives an offset in bits 15:0, and each later body word is written to address 0xA000 + offset + n, where n is the index of that data word counting from 0.
- R3: Opcode 0x76 is a shader register set with the same layout as R2, using base 0xC000 minus 0x9400, that is 0x2C00.
- R4: Opcode 0x79 is a user-config register set with base 0xC000. For all three classes the addresses are taken modulo 2^16, and each write appears on regWrEn/regWrAddr/regWrData in the cycle after its data word is accepted. A set packet with count 0 writes nothing.
- R5: Opcode 0x85 adds one to deCount. deCount is 0 after reset.
- R6: Opcode 0x86 deasserts cmdReady after its header while ceCount <= deCount, compared unsigned. Once ceCount > deCount, the body words are accepted, and deCount does not change.
- R7: Opcodes 0x15, 0x27, 0x2A, 0x2D, 0x37, 0x3C, 0x46, 0x47, 0x48, 0x50 and 0x58 are forwarded. opStrobe pulses with opCode in the cycle after the header, and each body word appears on opWord with opWordValid in the cycle after it is accepted.
- R8: Opcode 0x10 is a no-op. When its count field is 0 it has no effect. When the count is non-zero and the first body word equals FLIP_MARKER (default 0x464C4950), flipIrq pulses for one cycle.
- R9: A type-3 header with any other opcode sets errFlag, which stays set until reset. Its body words are consumed with no write, strobe or pulse.
- R10: A header whose type is not 3 sets errFlag and is consumed as a single word.
- R11: After reset, cmdReady is 1 and regWrEn, opStrobe, opWordValid, flipIrq and errFlag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command word present |
| cmdWord | input | 32 | Command word |
| cmdReady | output | 1 | Word is accepted when cmdValid and cmdReady are both high |
| ceCount | input | CNT_W | Constant engine counter |
| deCount | output | CNT_W | Draw engine counter |
| regWrEn | output | 1 | Register write strobe |
| regWrAddr | output | ADDR_W | Register word address |
| regWrData | output | 32 | Register write data |
| opStrobe | output | 1 | Forwarded opcode strobe |
| opCode | output | 8 | Forwarded opcode |
| opWordValid | output | 1 | Forwarded body word strobe |
| opWord | output | 32 | Forwarded body word |
| flipIrq | output | 1 | Flip pulse |
| errFlag | output | 1 | Sticky error flag |

## Verification
A wrong remaining-word count or class register in the control misframes the next packet. The bench shows this within a packet or two: a data word is taken as a header, so a write lands at the wrong address or an unexpected strobe or error appears, and the scoreboard sees the mismatch on the next output. A wrong address counter shows up on the second write of a burst. A wrong counter comparison shows up either as cmdReady rising while the companion counter is still behind, or as a stall that never ends, which the watchdog turns into a failure.

// File: rtl/cmd_parser_pkg.sv
package cmd_parser_pkg;
  localparam logic [7:0] OP_SET_CTX   = 8'h69;
  localparam logic [7:0] OP_SET_SH    = 8'h76;
  localparam logic [7:0] OP_SET_UCFG  = 8'h79;
  localparam logic [7:0] OP_INC_DE    = 8'h85;
  localparam logic [7:0] OP_WAIT_CE   = 8'h86;
  localparam logic [7:0] OP_NOP       = 8'h10;

  typedef enum logic [2:0] {
    CLS_CTX, CLS_SH, CLS_UCFG, CLS_NOP, CLS_FWD, CLS_INC, CLS_WAIT, CLS_BAD
  } pktClass_e;

  typedef struct packed {
    logic      loadAddr;
    logic      writeReg;
    logic      incDe;
    logic      fwdHdr;
    logic      fwdWord;
    logic      flip;
    logic      badPkt;
    pktClass_e cls;
  } ctrlStrobes_t;

  function automatic pktClass_e classify(input logic [7:0] op);
    case (op)
      OP_SET_CTX:  classify = CLS_CTX;
      OP_SET_SH:   classify = CLS_SH;
      OP_SET_UCFG: classify = CLS_UCFG;
      OP_NOP:      classify = CLS_NOP;
      OP_INC_DE:   classify = CLS_INC;
      OP_WAIT_CE:  classify = CLS_WAIT;
      8'h15, 8'h27, 8'h2A, 8'h2D, 8'h37, 8'h3C,
      8'h46, 8'h47, 8'h48, 8'h50, 8'h58: classify = CLS_FWD;
      default:     classify = CLS_BAD;
    endcase
  endfunction
endpackage

// File: rtl/cmd_parser_ctrl.sv
module cmd_parser_ctrl
  import cmd_parser_pkg::*;
#(
  parameter logic [31:0] FLIP_MARKER = 32'h464C_4950
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [31:0]  cmdWord,
  input  logic         ceAhead,
  output logic         cmdReady,
  output ctrlStrobes_t strb
);
  localparam int LEN_W = 15;

  typedef enum logic [1:0] {ST_HDR, ST_BODY, ST_WAIT} state_e;

  state_e     state;
  pktClass_e  clsQ;
  logic [LEN_W-1:0] remain;
  logic       firstWord;
  logic       nopLive;

  logic       accept;
  logic [1:0] hType;
  logic [13:0] hCnt;
  pktClass_e  hCls;

  assign cmdReady = (state != ST_WAIT);
  assign accept   = cmdValid && cmdReady;
  assign hType    = cmdWord[31:30];
  assign hCnt     = cmdWord[29:16];
  assign hCls     = classify(cmdWord[15:8]);

  always_comb begin
    strb = '0;
    strb.cls = (state == ST_HDR) ? hCls : clsQ;
    if (accept && state == ST_HDR) begin
      if (hType != 2'd3 || hCls == CLS_BAD) strb.badPkt = 1'b1;
      else begin
        strb.incDe  = (hCls == CLS_INC);
        strb.fwdHdr = (hCls == CLS_FWD);
      end
    end else if (accept && state == ST_BODY) begin
      case (clsQ)
        CLS_CTX, CLS_SH, CLS_UCFG: begin
          strb.loadAddr = firstWord;
          strb.writeReg = !firstWord;
        end
        CLS_NOP: strb.flip    = firstWord && nopLive && (cmdWord == FLIP_MARKER);
        CLS_FWD: strb.fwdWord = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HDR;
      clsQ      <= CLS_BAD;
      remain    <= '0;
      firstWord <= 1'b0;
      nopLive   <= 1'b0;
    end else begin
      case (state)
        ST_HDR: if (accept && hType == 2'd3) begin
          clsQ      <= hCls;
          remain    <= LEN_W'(hCnt) + LEN_W'(1);
          firstWord <= 1'b1;
          nopLive   <= (hCnt != 14'd0);
          state     <= (hCls == CLS_WAIT) ? ST_WAIT : ST_BODY;
        end
        ST_WAIT: if (ceAhead) state <= ST_BODY;
        default: if (accept) begin
          firstWord <= 1'b0;
          remain    <= remain - LEN_W'(1);
          if (remain == LEN_W'(1)) state <= ST_HDR;
        end
      endcase
    end
  end

  // R6: the stall holds until the companion counter is ahead
  assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !ceAhead) |=> (state == ST_WAIT));
  // R1: a packet body is never entered with nothing left to read
  assert_body_nonempty_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BODY) |-> (remain != '0));
endmodule

// File: rtl/cmd_parser_dpath.sv
module cmd_parser_dpath
  import cmd_parser_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              CNT_W     = 32,
  parameter logic [ADDR_W-1:0] CTX_BASE  = 16'hA000,
  parameter logic [ADDR_W-1:0] SH_BASE   = 16'h2C00,
  parameter logic [ADDR_W-1:0] UCFG_BASE = 16'hC000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       cmdWord,
  input  ctrlStrobes_t      strb,
  input  logic [CNT_W-1:0]  ceCount,
  output logic              ceAhead,
  output logic [CNT_W-1:0]  deCount,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [31:0]       regWrData,
  output logic              opStrobe,
  output logic [7:0]        opCode,
  output logic              opWordValid,
  output logic [31:0]       opWord,
  output logic              flipIrq,
  output logic              errFlag
);
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] base;

  assign ceAhead = (ceCount > deCount);

  always_comb begin
    case (strb.cls)
      CLS_SH:   base = SH_BASE;
      CLS_UCFG: base = UCFG_BASE;
      default:  base = CTX_BASE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ       <= '0;
      deCount     <= '0;
      regWrEn     <= 1'b0;
      regWrAddr   <= '0;
      regWrData   <= '0;
      opStrobe    <= 1'b0;
      opCode      <= '0;
      opWordValid <= 1'b0;
      opWord      <= '0;
      flipIrq     <= 1'b0;
      errFlag     <= 1'b0;
    end else begin
      regWrEn     <= strb.writeReg;
      opStrobe    <= strb.fwdHdr;
      opWordValid <= strb.fwdWord;
      flipIrq     <= strb.flip;
      if (strb.badPkt) errFlag <= 1'b1;
      if (strb.incDe) deCount <= deCount + CNT_W'(1);
      if (strb.loadAddr) addrQ <= base + cmdWord[ADDR_W-1:0];
      if (strb.writeReg) begin
        regWrAddr <= addrQ;
        regWrData <= cmdWord;
        addrQ     <= addrQ + ADDR_W'(1);
      end
      if (strb.fwdHdr) opCode <= cmdWord[15:8];
      if (strb.fwdWord) opWord <= cmdWord;
    end
  end

  // R4: back-to-back writes belong to one burst and step by one address
  assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && $past(regWrEn)) |-> (regWrAddr == $past(regWrAddr) + ADDR_W'(1)));
  // R5: the draw counter only ever moves up by one
  assert_de_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (deCount != $past(deCount)) |-> (deCount == $past(deCount) + CNT_W'(1)));
  // R8: flip is a single-cycle pulse
  assert_flip_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    flipIrq |=> !flipIrq);
  // R9: the error flag is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  // R7: a forwarded strobe never coincides with a register write
  assert_excl_out_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(opStrobe && regWrEn));
endmodule

// File: rtl/cmd_parser.sv
module cmd_parser
  import cmd_parser_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              CNT_W       = 32,
  parameter logic [ADDR_W-1:0] CTX_BASE    = 16'hA000,
  parameter logic [ADDR_W-1:0] SH_BASE     = 16'h2C00,
  parameter logic [ADDR_W-1:0] UCFG_BASE   = 16'hC000,
  parameter logic [31:0]     FLIP_MARKER = 32'h464C_4950
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [31:0]       cmdWord,
  output logic              cmdReady,
  input  logic [CNT_W-1:0]  ceCount,
  output logic [CNT_W-1:0]  deCount,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] regWrAddr,
  output logic [31:0]       regWrData,
  output logic              opStrobe,
  output logic [7:0]        opCode,
  output logic              opWordValid,
  output logic [31:0]       opWord,
  output logic              flipIrq,
  output logic              errFlag
);
  ctrlStrobes_t strb;
  logic         ceAhead;

  cmd_parser_ctrl #(.FLIP_MARKER(FLIP_MARKER)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .ceAhead(ceAhead), .cmdReady(cmdReady), .strb(strb)
  );

  cmd_parser_dpath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .CTX_BASE(CTX_BASE), .SH_BASE(SH_BASE), .UCFG_BASE(UCFG_BASE)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .cmdWord(cmdWord), .strb(strb), .ceCount(ceCount),
    .ceAhead(ceAhead), .deCount(deCount), .regWrEn(regWrEn),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .opStrobe(opStrobe),
    .opCode(opCode), .opWordValid(opWordValid), .opWord(opWord),
    .flipIrq(flipIrq), .errFlag(errFlag)
  );
endmodule

// File: tb/cmd_parser_tb.sv
module cmd_parser_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [31:0] cmdWord = '0;
  logic        cmdReady;
  logic [31:0] ceCount = '0;
  logic [31:0] deCount;
  logic        regWrEn;
  logic [15:0] regWrAddr;
  logic [31:0] regWrData;
  logic        opStrobe;
  logic [7:0]  opCode;
  logic        opWordValid;
  logic [31:0] opWord;
  logic        flipIrq;
  logic        errFlag;

  int checks = 0;
  int fails = 0;
  int flips = 0;
  bit done = 1'b0;

  logic [47:0] expWr[$];
  string       expWrTag[$];
  logic [7:0]  expOp[$];
  logic [31:0] expOpWord[$];

  localparam logic [31:0] MARK = 32'h464C_4950;

  always #2 clk = ~clk;

  cmd_parser u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .cmdReady(cmdReady), .ceCount(ceCount), .deCount(deCount),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .opStrobe(opStrobe), .opCode(opCode), .opWordValid(opWordValid),
    .opWord(opWord), .flipIrq(flipIrq), .errFlag(errFlag)
  );

  function automatic logic [31:0] hdr(input logic [7:0] op, input int cnt);
    return {2'b11, 14'(cnt), op, 8'h00};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [31:0] w);
    cmdValid = 1'b1;
    cmdWord  = w;
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // Register-set packet: pushes the expected writes, then drives the words
  task automatic setPkt(input logic [7:0] op, input logic [15:0] base, input logic [15:0] off,
                        input int n, input logic [31:0] seed, input string tag);
    for (int i = 0; i < n; i++) begin
      expWr.push_back({16'(base + off + 16'(i)), seed + 32'(i)});
      expWrTag.push_back(tag);
    end
    sendWord(hdr(op, n));
    sendWord({16'h0, off});
    for (int i = 0; i < n; i++) sendWord(seed + 32'(i));
  endtask

  // Scoreboard monitor
  always @(negedge clk) if (rstN) begin
    if (regWrEn) begin
      if (expWr.size() == 0) check(1'b0, "R9 unexpected write", {16'h0, regWrAddr, regWrData}, 0);
      else begin
        logic [47:0] e;
        string t;
        e = expWr.pop_front();
        t = expWrTag.pop_front();
        check({regWrAddr, regWrData} == e, t, {16'h0, regWrAddr, regWrData}, {16'h0, e});
      end
    end
    if (opStrobe) begin
      if (expOp.size() == 0) check(1'b0, "R7 unexpected strobe", 64'(opCode), 0);
      else begin
        logic [7:0] e;
        e = expOp.pop_front();
        check(opCode == e, "R7 opcode", 64'(opCode), 64'(e));
      end
    end
    if (opWordValid) begin
      if (expOpWord.size() == 0) check(1'b0, "R7 unexpected word", 64'(opWord), 0);
      else begin
        logic [31:0] e;
        e = expOpWord.pop_front();
        check(opWord == e, "R7 body word", 64'(opWord), 64'(e));
      end
    end
    if (flipIrq) flips++;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(cmdReady == 1'b1, "R11 cmdReady", 64'(cmdReady), 1);
    check(!regWrEn && !opStrobe && !opWordValid && !flipIrq, "R11 strobes", 64'({regWrEn, opStrobe, opWordValid, flipIrq}), 0);
    check(errFlag == 1'b0, "R11 errFlag", 64'(errFlag), 0);
    check(deCount == 0, "R5 deCount reset", 64'(deCount), 0);
    rstN = 1'b1;
    @(negedge clk);

    setPkt(8'h69, 16'hA000, 16'h0005, 2, 32'h1111_0000, "R2 context write");
    setPkt(8'h76, 16'h2C00, 16'h0010, 3, 32'h2222_0000, "R3 shader write");
    setPkt(8'h79, 16'hC000, 16'h3FFE, 3, 32'h3333_0000, "R4 uconfig write with wrap");
    // R4 / R1: count 0 set packet writes nothing, next packet framed right
    sendWord(hdr(8'h69, 0));
    sendWord(32'h0000_0040);
    setPkt(8'h69, 16'hA000, 16'h0100, 1, 32'h4444_0000, "R1 framing after empty set");

    // R7: forwarded draw packet
    expOp.push_back(8'h2D);
    expOpWord.push_back(32'hDEAD_0001);
    expOpWord.push_back(32'hDEAD_0002);
    sendWord(hdr(8'h2D, 1));
    sendWord(32'hDEAD_0001);
    sendWord(32'hDEAD_0002);

    // R8: no-op handling
    sendWord(hdr(8'h10, 0)); sendWord(MARK);          // ignored
    sendWord(hdr(8'h10, 1)); sendWord(32'h1); sendWord(MARK); // marker not first
    sendWord(hdr(8'h10, 1)); sendWord(MARK); sendWord(32'h0); // flip
    repeat (2) @(negedge clk);
    check(flips == 1, "R8 flip count", 64'(flips), 1);

    // R5: counter increment
    sendWord(hdr(8'h85, 0)); sendWord(32'h0);
    @(negedge clk);
    check(deCount == 1, "R5 deCount", 64'(deCount), 1);

    // R6: stall while ceCount <= deCount
    ceCount = 32'd1;
    fork
      begin
        sendWord(hdr(8'h86, 0));
        sendWord(32'h0);
      end
      begin
        repeat (4) @(negedge clk);
        check(cmdReady == 1'b0, "R6 stalled at equal counts", 64'(cmdReady), 0);
        ceCount = 32'd2;
      end
    join
    check(deCount == 1, "R6 deCount unchanged", 64'(deCount), 1);
    setPkt(8'h79, 16'hC000, 16'h0002, 1, 32'h5555_0000, "R6 flow resumes");

    // R9: unknown opcode, body shaped like headers must be swallowed
    repeat (2) @(negedge clk);
    check(errFlag == 1'b0, "R9 no error before", 64'(errFlag), 0);
    sendWord(hdr(8'hEE, 1));
    sendWord(hdr(8'h69, 0));
    sendWord(hdr(8'h2D, 0));
    @(negedge clk);
    check(errFlag == 1'b1, "R9 errFlag set", 64'(errFlag), 1);
    setPkt(8'h76, 16'h2C00, 16'h0020, 2, 32'h6666_0000, "R9 resync after unknown");

    // R10: non-type-3 word is a single dropped word
    sendWord(32'h4069_0000);
    setPkt(8'h69, 16'hA000, 16'h0030, 1, 32'h7777_0000, "R10 resync after bad type");
    repeat (4) @(negedge clk);
    check(errFlag == 1'b1, "R10 errFlag held", 64'(errFlag), 1);
    check(expWr.size() == 0, "R4 all writes seen", 64'(expWr.size()), 0);
    check(expOp.size() == 0 && expOpWord.size() == 0, "R7 all forwards seen",
          64'(expOp.size() + expOpWord.size()), 0);
    check(flips == 1, "R8 no extra flips", 64'(flips), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung (R6 stall) actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule